// File: doc/BRIEF.md
# Two-Wire Bus Register-Access Slave

This block is a slave on a two-wire serial bus (clock line plus open-drain data line). A host uses it to read and write a byte-wide register file of 128 entries, which sits outside the block behind a simple synchronous read/write port. The bus lines are brought into the system clock domain through a short synchronizer chain. From that point START, repeated START, STOP and the clock edges are detected by sampling. Data moves most significant bit first.

The 7-bit device address is formed from four address pins sampled while reset is held, with the three upper bits fixed at zero. In a write, the first data byte does not reach the register file. It loads an internal pointer byte whose low seven bits select a register and whose top bit freezes the pointer. Later bytes are written at the pointer. A read returns bytes starting at the pointer. The usual combined transfer is a pointer write, then a repeated START, then a read.

The register file must return read data one clock after the read strobe. The pointer never wraps: it stops at the last register.

Top module: `twi_regfile_slave`

## Requirements
- R1: The slave responds only to the device address {3'b000, addr_pins}, where addr_pins is sampled during the clock cycles with rst high. Changes on the pins after reset have no effect. The address byte is sent as the address followed by a direction bit, 1 meaning read.
- R2: The slave pulls the data line low during the ninth clock of every transfer byte it accepts: its own address byte, and each byte written to it.
- R3: The first byte after a write address loads the pointer byte and does not reach the register file. Bit 7 of that byte is the freeze flag and bits 6:0 are the register index.
- R4: With the freeze flag clear, each further written byte is stored at the pointer, and the pointer then moves to the next register. No register-file write and read strobe are ever active in the same cycle.
- R5: With the freeze flag set, the pointer does not move, so all writes and reads in that transfer use the same register.
- R6: When the pointer reaches register 127 it stays there. Further bytes in either direction use register 127 until the pointer is cleared or reloaded.
- R7: A STOP that follows a matched address clears both the pointer and the freeze flag to zero. A repeated START leaves them as they were, so a read issued right after a STOP starts at register 0.
- R8: A read transfer returns the register at the pointer, MSB first. The pointer then advances after each byte sent, under the same rules as writes.
- R9: When the host answers a read byte with NACK, the slave releases the data line and does not drive it again until the next START.
- R10: After a non-matching address the slave neither drives the line, writes a register nor changes the pointer until the next START.
- R11: After reset the data line is released, both register-file strobes are low and the pointer reads from register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset; the address pins are sampled while it is high |
| addr_pins | input | 4 | Low four bits of the device address |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull_low | output | 1 | 1 pulls the data line low; 0 releases it |
| reg_addr | output | 7 | Register-file index for the current access |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid one cycle after reg_rd |

## Verification
Every 7-bit address is offered to one pin setting. After a second reset with different pins and a later pin change, the low addresses are offered again, which separates "pins latched" from "pins followed live". Patterned data is written across all 128 registers and read back in one auto-incrementing burst, showing that the pointer byte never lands in the file and that reads after a STOP start at zero. Shorter transfers target one behaviour each and are read back through the bus: frozen pointer, saturation at 127, repeated START keeping the pointer, NACK release and a foreign address slipped between two valid accesses.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int SLV_AW = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_IGNORE
  } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_chain;
  logic [STAGES-1:0] sda_chain;
  logic scl_p, sda_p, scl_s;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) begin
            scl_chain[g] <= 1'b1;
            sda_chain[g] <= 1'b1;
          end else begin
            scl_chain[g] <= scl_in;
            sda_chain[g] <= sda_in;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) begin
            scl_chain[g] <= 1'b1;
            sda_chain[g] <= 1'b1;
          end else begin
            scl_chain[g] <= scl_chain[g-1];
            sda_chain[g] <= sda_chain[g-1];
          end
        end
      end
    end
  endgenerate

  assign scl_s = scl_chain[STAGES-1];
  assign sda_s = sda_chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  // Data edges while the clock stays high frame a transfer.
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/twi_addr_latch.sv
module twi_addr_latch #(
  parameter int PIN_W = 4,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PIN_W-1:0]  pins,
  output logic [ADDR_W-1:0] dev_addr
);
  localparam int ZERO_W = ADDR_W - PIN_W;

  // Captured every cycle reset is held; frozen afterwards.
  always_ff @(posedge clk) begin
    if (rst) dev_addr <= {{ZERO_W{1'b0}}, pins};
  end
endmodule

// File: rtl/twi_pointer.sv
module twi_pointer #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          load,
  input  logic [AW:0]   load_val,
  input  logic          advance,
  output logic [AW-1:0] ptr,
  output logic          inhibit
);
  localparam logic [AW-1:0] PTR_MAX = {AW{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      ptr     <= '0;
      inhibit <= 1'b0;
    end else if (load) begin
      ptr     <= load_val[AW-1:0];
      inhibit <= load_val[AW];
    end else if (advance && !inhibit && ptr != PTR_MAX) begin
      ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/twi_regfile_slave.sv
module twi_regfile_slave #(
  parameter int REG_AW      = 7,
  parameter int DATA_W      = 8,
  parameter int PIN_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PIN_W-1:0]  addr_pins,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull_low,
  output logic [REG_AW-1:0] reg_addr,
  output logic              reg_wr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata
);
  import twi_pkg::*;

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [SLV_AW-1:0] dev_addr;
  logic [REG_AW-1:0] ptr;
  logic inhibit;
  logic ptr_clear, ptr_load, ptr_adv;

  twi_state_e        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] rx_shift, tx_shift, tx_buf;
  logic rw_bit, first_byte, matched, rd_wait;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  twi_addr_latch #(.PIN_W(PIN_W), .ADDR_W(SLV_AW)) u_addr (
    .clk(clk), .rst(rst), .pins(addr_pins), .dev_addr(dev_addr)
  );

  twi_pointer #(.AW(REG_AW)) u_ptr (
    .clk(clk), .rst(rst), .clear(ptr_clear), .load(ptr_load),
    .load_val(rx_shift[REG_AW:0]), .advance(ptr_adv),
    .ptr(ptr), .inhibit(inhibit)
  );

  always_comb begin
    ptr_clear = stop_evt & matched;
    ptr_load  = scl_fall & (state == ST_WR_BYTE) & (bit_cnt == LAST_BIT) & first_byte;
    ptr_adv   = scl_fall & (bit_cnt == LAST_BIT) &
                (((state == ST_WR_BYTE) & ~first_byte) | (state == ST_RD_BYTE));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      bit_cnt      <= '0;
      rx_shift     <= '0;
      tx_shift     <= '0;
      tx_buf       <= '0;
      rw_bit       <= 1'b0;
      first_byte   <= 1'b0;
      matched      <= 1'b0;
      rd_wait      <= 1'b0;
      sda_pull_low <= 1'b0;
      reg_addr     <= '0;
      reg_wr       <= 1'b0;
      reg_wdata    <= '0;
      reg_rd       <= 1'b0;
    end else begin
      reg_wr  <= 1'b0;
      reg_rd  <= 1'b0;
      rd_wait <= reg_rd;
      if (rd_wait) tx_buf <= reg_rdata;

      if (start_evt) begin
        state        <= ST_ADDR;
        bit_cnt      <= '0;
        sda_pull_low <= 1'b0;
      end else if (stop_evt) begin
        state        <= ST_IDLE;
        sda_pull_low <= 1'b0;
        matched      <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              rx_shift <= {rx_shift[DATA_W-2:0], sda_s};
              bit_cnt  <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == LAST_BIT) begin
              if (rx_shift[DATA_W-1:1] == dev_addr) begin
                matched      <= 1'b1;
                rw_bit       <= rx_shift[0];
                sda_pull_low <= 1'b1;
                state        <= ST_ADDR_ACK;
                if (rx_shift[0]) begin
                  reg_rd   <= 1'b1;
                  reg_addr <= ptr;
                end
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rw_bit) begin
                state        <= ST_RD_BYTE;
                tx_shift     <= tx_buf;
                sda_pull_low <= ~tx_buf[DATA_W-1];
              end else begin
                state        <= ST_WR_BYTE;
                first_byte   <= 1'b1;
                sda_pull_low <= 1'b0;
              end
            end
          end
          ST_WR_BYTE: begin
            if (scl_rise) begin
              rx_shift <= {rx_shift[DATA_W-2:0], sda_s};
              bit_cnt  <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == LAST_BIT) begin
              sda_pull_low <= 1'b1;
              state        <= ST_WR_ACK;
              if (!first_byte) begin
                reg_wr    <= 1'b1;
                reg_addr  <= ptr;
                reg_wdata <= rx_shift;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_pull_low <= 1'b0;
              first_byte   <= 1'b0;
              bit_cnt      <= '0;
              state        <= ST_WR_BYTE;
            end
          end
          ST_RD_BYTE: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall) begin
              if (bit_cnt == LAST_BIT) begin
                sda_pull_low <= 1'b0;
                state        <= ST_RD_ACK;
              end else begin
                tx_shift     <= {tx_shift[DATA_W-2:0], 1'b0};
                sda_pull_low <= ~tx_shift[DATA_W-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              if (sda_s) begin
                state <= ST_IGNORE;
              end else begin
                reg_rd   <= 1'b1;
                reg_addr <= ptr;
              end
            end else if (scl_fall) begin
              state        <= ST_RD_BYTE;
              bit_cnt      <= '0;
              tx_shift     <= tx_buf;
              sda_pull_low <= ~tx_buf[DATA_W-1];
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_regfile_slave_chk.sv
module twi_regfile_slave_chk #(
  parameter int REG_AW = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              matched,
  input logic              ptr_load,
  input logic [REG_AW-1:0] ptr,
  input logic              inhibit,
  input twi_pkg::twi_state_e state,
  input logic              sda_pull_low,
  input logic              reg_wr,
  input logic              reg_rd
);
  localparam logic [REG_AW-1:0] PTR_MAX = {REG_AW{1'b1}};

  // R6
  ptr_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (ptr == PTR_MAX && !ptr_load && !stop_evt) |=> ptr == PTR_MAX);

  // R5
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (inhibit && !ptr_load && !stop_evt) |=> $stable(ptr));

  // R7
  stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_evt && matched) |=> (ptr == '0 && !inhibit));

  // R7
  start_keep_chk: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> ($stable(ptr) && $stable(inhibit)));

  // R10
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == twi_pkg::ST_IGNORE) |-> (!sda_pull_low && !reg_wr && !ptr_load));

  // R4
  wr_rd_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_rd));
endmodule

bind twi_regfile_slave twi_regfile_slave_chk #(.REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst(rst), .start_evt(start_evt), .stop_evt(stop_evt),
  .matched(matched), .ptr_load(ptr_load), .ptr(ptr), .inhibit(inhibit),
  .state(state), .sda_pull_low(sda_pull_low), .reg_wr(reg_wr), .reg_rd(reg_rd)
);

// File: tb/sim_twi_regfile_slave.sv
module sim_twi_regfile_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] addr_pins = 4'hA;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull_low, reg_wr, reg_rd;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic sda_bus;

  int checks = 0, failures = 0;
  int wr_count = 0;
  logic mem_clr = 1'b1;
  logic [7:0] mem [128];
  logic       written [128];
  logic [7:0] expv [128];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull_low;

  twi_regfile_slave u0 (
    .clk(clk), .rst(rst), .addr_pins(addr_pins), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_pull_low(sda_pull_low), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] seed_val(input int i);
    return 8'((i * 37 + 11) ^ 8'h5A);
  endfunction

  // Register file model: one-cycle read latency.
  always @(posedge clk) begin
    if (mem_clr) begin
      for (int i = 0; i < 128; i++) written[i] <= 1'b0;
    end else begin
      if (reg_wr) begin
        mem[reg_addr]     <= reg_wdata;
        written[reg_addr] <= 1'b1;
        wr_count          <= wr_count + 1;
      end
      if (reg_rd) reg_rdata <= written[reg_addr] ? mem[reg_addr] : seed_val(int'(reg_addr));
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait(); qwait();
  endtask

  task automatic clk_bit(input logic b, output logic r);
    sda_m = b; qwait();
    scl_m = 1'b1; qwait();
    r = sda_bus; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], r);
    clk_bit(1'b1, r);
    acked = ~r;
  endtask

  task automatic recv_byte(input logic master_ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      d[i] = r;
    end
    clk_bit(~master_ack, r);
  endtask

  task automatic do_reset(input logic [3:0] pins);
    rst = 1'b1; addr_pins = pins;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    addr_pins = ~pins;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic ak;
    logic [7:0] d;
    int wc;
    for (int i = 0; i < 128; i++) expv[i] = seed_val(i);
    repeat (2) @(negedge clk);
    mem_clr = 1'b0;
    do_reset(4'hA);

    // R11 reset state
    check("R11 sda released", int'(sda_pull_low), 0);
    check("R11 wr strobe", int'(reg_wr), 0);
    check("R11 rd strobe", int'(reg_rd), 0);
    bus_start(); send_byte({7'h0A, 1'b1}, ak); recv_byte(1'b0, d); bus_stop();
    check("R11 first read at reg 0", int'(d), int'(expv[0]));

    // R1 sweep of every address, pins 0xA
    for (int a = 0; a < 128; a++) begin
      bus_start(); send_byte({7'(a), 1'b0}, ak); bus_stop();
      check($sformatf("R1 ack addr 0x%0h", a), int'(ak), int'(a == 8'h0A));
    end
    check("R10 no writes during sweep", wr_count, 0);

    // R2 R3 R4 write with auto-increment
    bus_start(); send_byte({7'h0A, 1'b0}, ak);
    check("R2 address ack", int'(ak), 1);
    send_byte(8'h10, ak);
    check("R2 pointer byte ack", int'(ak), 1);
    for (int k = 0; k < 3; k++) begin
      send_byte(8'hC0 + 8'(k), ak);
      expv[16 + k] = 8'hC0 + 8'(k);
      check("R2 data ack", int'(ak), 1);
    end
    check("R3 pointer byte not written", wr_count, 3);

    // R7 R8 repeated START keeps the pointer (now 0x13)
    bus_rstart(); send_byte({7'h0A, 1'b1}, ak);
    recv_byte(1'b1, d); check("R7 R8 read after rstart", int'(d), int'(expv[19]));
    recv_byte(1'b0, d); check("R8 read advances", int'(d), int'(expv[20]));
    bus_rstart(); send_byte({7'h0A, 1'b0}, ak); send_byte(8'h10, ak);
    bus_rstart(); send_byte({7'h0A, 1'b1}, ak);
    for (int k = 0; k < 3; k++) begin
      recv_byte(k != 2, d);
      check("R4 written data", int'(d), int'(expv[16 + k]));
    end
    bus_stop();

    // R7 read after STOP starts at 0
    bus_start(); send_byte({7'h0A, 1'b1}, ak);
    recv_byte(1'b1, d); check("R7 read after stop reg0", int'(d), int'(expv[0]));
    recv_byte(1'b0, d); check("R7 then reg1", int'(d), int'(expv[1]));
    bus_stop();

    // R5 frozen pointer
    wc = wr_count;
    bus_start(); send_byte({7'h0A, 1'b0}, ak); send_byte(8'hA0, ak);
    send_byte(8'h11, ak); send_byte(8'h22, ak); send_byte(8'h33, ak);
    expv[32] = 8'h33;
    bus_rstart(); send_byte({7'h0A, 1'b1}, ak);
    recv_byte(1'b1, d); check("R5 frozen write", int'(d), 8'h33);
    recv_byte(1'b0, d); check("R5 frozen read", int'(d), 8'h33);
    bus_stop();
    check("R5 three writes", wr_count - wc, 3);
    bus_start(); send_byte({7'h0A, 1'b0}, ak); send_byte(8'h21, ak);
    bus_rstart(); send_byte({7'h0A, 1'b1}, ak);
    recv_byte(1'b0, d); bus_stop();
    check("R5 neighbour untouched", int'(d), int'(expv[33]));

    // R6 saturation at 127
    bus_start(); send_byte({7'h0A, 1'b0}, ak); send_byte(8'h7E, ak);
    for (int k = 0; k < 4; k++) send_byte(8'h50 + 8'(k), ak);
    expv[126] = 8'h50; expv[127] = 8'h53;
    bus_rstart(); send_byte({7'h0A, 1'b1}, ak);
    for (int k = 0; k < 3; k++) begin
      recv_byte(k != 2, d);
      check("R6 saturated read", int'(d), 8'h53);
    end
    bus_stop();
    bus_start(); send_byte({7'h0A, 1'b0}, ak); send_byte(8'h7E, ak);
    bus_rstart(); send_byte({7'h0A, 1'b1}, ak);
    recv_byte(1'b0, d); bus_stop();
    check("R6 reg 126", int'(d), 8'h50);

    // R9 NACK releases the line
    bus_start(); send_byte({7'h0A, 1'b1}, ak);
    recv_byte(1'b0, d);
    recv_byte(1'b0, d);
    check("R9 line released after NACK", int'(d), 8'hFF);
    bus_stop();

    // R10 foreign address between valid accesses
    bus_start(); send_byte({7'h0A, 1'b0}, ak); send_byte(8'h30, ak);
    wc = wr_count;
    bus_rstart(); send_byte({7'h1A, 1'b0}, ak);
    check("R10 no ack foreign", int'(ak), 0);
    send_byte(8'h05, ak); check("R10 no data ack", int'(ak), 0);
    send_byte(8'h99, ak);
    bus_rstart(); send_byte({7'h0A, 1'b1}, ak);
    recv_byte(1'b0, d); bus_stop();
    check("R10 pointer kept", int'(d), int'(expv[48]));
    check("R10 no writes", wr_count - wc, 0);

    // R4 R8 full fill and burst readback
    bus_start(); send_byte({7'h0A, 1'b0}, ak); send_byte(8'h00, ak);
    for (int k = 0; k < 128; k++) begin
      send_byte(8'(k * 3 + 1) ^ 8'hA5, ak);
      expv[k] = 8'(k * 3 + 1) ^ 8'hA5;
    end
    bus_stop();
    bus_start(); send_byte({7'h0A, 1'b1}, ak);
    for (int k = 0; k < 128; k++) begin
      recv_byte(k != 127, d);
      check($sformatf("R8 burst reg %0d", k), int'(d), int'(expv[k]));
    end
    bus_stop();

    // R1 new pins latched, later pin change ignored
    do_reset(4'h5);
    for (int a = 0; a < 16; a++) begin
      bus_start(); send_byte({7'(a), 1'b0}, ak); bus_stop();
      check($sformatf("R1 relatch addr 0x%0h", a), int'(ak), int'(a == 5));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule